// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block is a single-level cache controller. It sits between a processor that issues word reads and writes and a slower main memory. The processor addresses bytes. Each cache line holds one data word, and the number of lines is a power-of-two parameter. The address is split into three fields: a byte offset within the word, a line index just above the offset, and a tag made of every bit above the index. Each line stores a valid flag, the tag and the data word.

A read that finds a valid line with a matching tag is answered from the line. Main memory is not touched. Any other read fetches the word from memory, forwards it to the processor and fills the line with it. Every write goes through to memory. A write also places the word and its tag in the indexed line, whether or not the line held that address before. No fetch comes first. Two counters report how many accepted accesses hit and how many missed.

The processor request channel is valid/ready. A request is taken on a clock edge where both `core_req_valid` and `core_req_ready` are high. Ready stays low for as long as a memory transaction is open. The processor side therefore sees one access at a time. The request fields must stay stable while valid is high and ready is low. The response is a one-cycle `core_rsp_valid` pulse with no back-pressure. The memory request channel is also valid/ready. The cache holds valid, address, write flag and write data stable until memory raises `mem_req_ready`. A write is complete on acceptance. Read data comes back later as a one-cycle `mem_rsp_valid` pulse.

Top module: `dmc_cache`

## Requirements
- R1: After reset no line is valid, so the first access to any line misses. Right after reset `core_req_ready` is 1, and `core_rsp_valid` and `mem_req_valid` are 0. Both counters read 0.
- R2: The lowest log2(DATA_W/8) address bits (bits 1:0 for 32-bit words) do not affect lookup. The next log2(LINES) bits select the line, and all bits above them form the tag. Memory request addresses have their offset bits at zero.
- R3: An access hits exactly when the indexed line is valid and its stored tag equals the address tag. Otherwise it misses.
- R4: A read hit returns the stored word with `core_rsp_valid` high in the cycle after acceptance. It issues no memory request.
- R5: A read miss issues exactly one memory read at the word-aligned address and returns the word memory supplied. Later reads of that address hit.
- R6: A write hit issues exactly one memory write carrying the address and data. It also updates the line, so a following read returns the new word.
- R7: A write miss issues exactly one memory write and no memory read. It installs the word and its tag in the indexed line, so a following read of that address hits.
- R8: While a memory request is pending, `core_req_ready` is 0. The memory request holds its address and write flag until `mem_req_ready` is seen.
- R9: Each accepted access adds one to exactly one of `hit_count` and `miss_count`.
- R10: Each accepted access produces exactly one single-cycle `core_rsp_valid` pulse. For writes the response data is the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req_valid | input | 1 | Processor request present |
| core_req_ready | output | 1 | Cache can accept a request |
| core_req_write | input | 1 | 1 = write, 0 = read |
| core_req_addr | input | ADDR_W | Byte address |
| core_req_wdata | input | DATA_W | Write data |
| core_rsp_valid | output | 1 | One-cycle response pulse |
| core_rsp_rdata | output | DATA_W | Read data, or the written word for writes |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = memory write, 0 = memory read |
| mem_req_addr | output | ADDR_W | Word-aligned byte address |
| mem_req_wdata | output | DATA_W | Write data to memory |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | DATA_W | Read data from memory |
| hit_count | output | CNT_W | Accepted accesses that hit |
| miss_count | output | CNT_W | Accepted accesses that missed |

## Verification
The bench runs on a four-line cache with an 8-bit address. A first sweep reads every one of the 64 words with rotating byte offsets, so each access misses and evicts another line that shares its index. This separates tag comparison from index selection. Repeated reads of the resident words, using all four offsets, must hit without memory traffic, which shows the offset is ignored. A write sweep followed by a read-back tells write misses from write hits: each must produce exactly one memory write and no read, and the read-back must hit. Two aliasing addresses are read in alternation to confirm that a tag mismatch on a valid line misses. Memory latencies vary between accesses to exercise the ready hold-off.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MREQ  = 2'd1,
    ST_MWAIT = 2'd2
  } dmc_state_e;
endpackage

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  line_vld;
  logic [TAG_W-1:0]  line_tag [LINES];
  logic [DATA_W-1:0] line_dat [LINES];

  always_ff @(posedge clk) begin
    if (rst) line_vld <= '0;
    else if (wr_en) line_vld[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      line_tag[wr_idx] <= wr_tag;
      line_dat[wr_idx] <= wr_data;
    end
  end

  assign lk_hit  = line_vld[lk_idx] && (line_tag[lk_idx] == lk_tag);
  assign lk_data = line_dat[lk_idx];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6,
  parameter int OFF_W  = 2,
  parameter int TAG_W  = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_req_valid,
  output logic              core_req_ready,
  input  logic              core_req_write,
  input  logic [ADDR_W-1:0] core_req_addr,
  input  logic [DATA_W-1:0] core_req_wdata,
  output logic              core_rsp_valid,
  output logic [DATA_W-1:0] core_rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [TAG_W-1:0]  lk_tag,
  input  logic              lk_hit,
  input  logic [DATA_W-1:0] lk_data,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [DATA_W-1:0] wr_data,
  output logic              hit_evt,
  output logic              miss_evt
);
  localparam logic [ADDR_W-1:0] WORD_MASK = ~((ADDR_W'(1) << OFF_W) - ADDR_W'(1));

  dmc_state_e        state;
  logic              op_write;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_wdata;
  logic              accept;

  assign core_req_ready = (state == ST_IDLE);
  assign accept         = core_req_valid && core_req_ready;

  assign lk_idx = core_req_addr[OFF_W +: IDX_W];
  assign lk_tag = core_req_addr[ADDR_W-1 -: TAG_W];

  assign hit_evt  = accept && lk_hit;
  assign miss_evt = accept && !lk_hit;

  assign mem_req_valid = (state == ST_MREQ);
  assign mem_req_write = op_write;
  assign mem_req_addr  = op_addr & WORD_MASK;
  assign mem_req_wdata = op_wdata;

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = lk_idx;
    wr_tag  = lk_tag;
    wr_data = core_req_wdata;
    if (state == ST_IDLE) begin
      wr_en = accept && core_req_write;
    end else begin
      wr_en   = (state == ST_MWAIT) && mem_rsp_valid;
      wr_idx  = op_addr[OFF_W +: IDX_W];
      wr_tag  = op_addr[ADDR_W-1 -: TAG_W];
      wr_data = mem_rsp_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      op_write       <= 1'b0;
      op_addr        <= '0;
      op_wdata       <= '0;
      core_rsp_valid <= 1'b0;
      core_rsp_rdata <= '0;
    end else begin
      core_rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          op_write <= core_req_write;
          op_addr  <= core_req_addr;
          op_wdata <= core_req_wdata;
          if (!core_req_write && lk_hit) begin
            core_rsp_valid <= 1'b1;
            core_rsp_rdata <= lk_data;
          end else begin
            state <= ST_MREQ;
          end
        end
        ST_MREQ: if (mem_req_ready) begin
          if (op_write) begin
            core_rsp_valid <= 1'b1;
            core_rsp_rdata <= op_wdata;
            state          <= ST_IDLE;
          end else begin
            state <= ST_MWAIT;
          end
        end
        ST_MWAIT: if (mem_rsp_valid) begin
          core_rsp_valid <= 1'b1;
          core_rsp_rdata <= mem_rsp_rdata;
          state          <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmc_counters.sv
module dmc_counters #(
  parameter int CNT_W = 16,
  parameter int NUM   = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM-1:0]        evt,
  output logic [NUM*CNT_W-1:0]  cnt
);
  for (genvar g = 0; g < NUM; g++) begin : g_cnt
    logic [CNT_W-1:0] val;
    always_ff @(posedge clk) begin
      if (rst) val <= '0;
      else if (evt[g]) val <= val + CNT_W'(1);
    end
    assign cnt[g*CNT_W +: CNT_W] = val;
  end
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 64,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_req_valid,
  output logic              core_req_ready,
  input  logic              core_req_write,
  input  logic [ADDR_W-1:0] core_req_addr,
  input  logic [DATA_W-1:0] core_req_wdata,
  output logic              core_rsp_valid,
  output logic [DATA_W-1:0] core_rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int IDX_W = $clog2(LINES);
  localparam int OFF_W = $clog2(DATA_W / 8);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [IDX_W-1:0]  lk_idx, wr_idx;
  logic [TAG_W-1:0]  lk_tag, wr_tag;
  logic [DATA_W-1:0] lk_data, wr_data;
  logic              lk_hit, wr_en, hit_evt, miss_evt;
  logic [2*CNT_W-1:0] cnt_bus;

  dmc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_data(lk_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data)
  );

  dmc_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .TAG_W(TAG_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .core_req_valid(core_req_valid), .core_req_ready(core_req_ready),
    .core_req_write(core_req_write), .core_req_addr(core_req_addr),
    .core_req_wdata(core_req_wdata),
    .core_rsp_valid(core_rsp_valid), .core_rsp_rdata(core_rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_data(lk_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data),
    .hit_evt(hit_evt), .miss_evt(miss_evt)
  );

  dmc_counters #(.CNT_W(CNT_W), .NUM(2)) u_cnt (
    .clk(clk), .rst(rst), .evt({miss_evt, hit_evt}), .cnt(cnt_bus)
  );

  assign hit_count  = cnt_bus[CNT_W-1:0];
  assign miss_count = cnt_bus[2*CNT_W-1:CNT_W];
endmodule

// File: rtl/dmc_cache_checks.sv
module dmc_cache_checks #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              core_req_valid,
  input logic              core_req_ready,
  input logic              core_req_write,
  input logic              core_rsp_valid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count
);
  localparam int OFF_W = $clog2(DATA_W / 8);

  logic             acc, rd_acc_q, wr_q;
  logic [CNT_W-1:0] total;

  assign acc   = core_req_valid && core_req_ready;
  assign total = hit_count + miss_count;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_acc_q <= 1'b0;
      wr_q     <= 1'b0;
    end else begin
      rd_acc_q <= acc && !core_req_write;
      if (acc) wr_q <= core_req_write;
    end
  end

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !core_req_ready); // R8
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)); // R8
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0)); // R2
  AST_READ_HIT_QUIET: assert property (@(posedge clk) disable iff (rst)
    rd_acc_q && (hit_count != $past(hit_count)) |-> core_rsp_valid && !mem_req_valid); // R4
  AST_ONE_COUNT: assert property (@(posedge clk) disable iff (rst)
    acc |=> total == $past(total) + CNT_W'(1)); // R9
  AST_OP_KIND: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> mem_req_write == wr_q); // R7
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
    core_rsp_valid |-> core_req_ready); // R10
endmodule

bind dmc_cache dmc_cache_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_checks (
  .clk(clk), .rst(rst),
  .core_req_valid(core_req_valid), .core_req_ready(core_req_ready),
  .core_req_write(core_req_write), .core_rsp_valid(core_rsp_valid),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/dmc_cache_test.sv
module dmc_cache_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NL = 4;
  localparam int CW = 16;
  localparam int NWORDS = 1 << (AW - 2);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          core_req_valid = 1'b0;
  logic          core_req_ready;
  logic          core_req_write = 1'b0;
  logic [AW-1:0] core_req_addr = '0;
  logic [DW-1:0] core_req_wdata = '0;
  logic          core_rsp_valid;
  logic [DW-1:0] core_rsp_rdata;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic          mem_req_write;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_rdata = '0;
  logic [CW-1:0] hit_count, miss_count;

  int tests = 0;
  int fails = 0;

  logic [DW-1:0] mem_model [NWORDS];
  logic          ref_vld [NL];
  logic [3:0]    ref_tag [NL];
  int            exp_hits = 0;
  int            exp_miss = 0;

  int  n_req, n_rd, n_wr, iters;
  bit  busy_bad, addr_bad, wdat_bad, pulse_bad;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmc_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst),
    .core_req_valid(core_req_valid), .core_req_ready(core_req_ready),
    .core_req_write(core_req_write), .core_req_addr(core_req_addr),
    .core_req_wdata(core_req_wdata),
    .core_rsp_valid(core_rsp_valid), .core_rsp_rdata(core_rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input int lat, output logic [DW-1:0] rd);
    int  wcnt = 0;
    int  rsp_wait = 0;
    bit  rsp_pending = 0;
    bit  done = 0;
    logic [AW-1:0] waddr;
    waddr = {a[AW-1:2], 2'b00};
    n_req = 0; n_rd = 0; n_wr = 0; iters = 0;
    busy_bad = 0; addr_bad = 0; wdat_bad = 0; pulse_bad = 0;
    rd = '0;
    @(negedge clk);
    core_req_valid = 1'b1;
    core_req_write = wr;
    core_req_addr  = a;
    core_req_wdata = wd;
    if (!core_req_ready) busy_bad = 1;
    while (!done && iters < 100) begin
      @(negedge clk);
      iters++;
      core_req_valid = 1'b0;
      mem_req_ready  = 1'b0;
      mem_rsp_valid  = 1'b0;
      if (core_rsp_valid) begin
        rd = core_rsp_rdata;
        done = 1;
      end else if (rsp_pending) begin
        if (rsp_wait == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_rdata = mem_model[waddr[AW-1:2]];
          rsp_pending = 0;
        end else rsp_wait--;
      end else if (mem_req_valid) begin
        if (core_req_ready) busy_bad = 1;
        if (wcnt == lat) begin
          mem_req_ready = 1'b1;
          n_req++;
          if (mem_req_addr !== waddr) addr_bad = 1;
          if (mem_req_write) begin
            n_wr++;
            if (mem_req_wdata !== wd) wdat_bad = 1;
            mem_model[mem_req_addr[AW-1:2]] = mem_req_wdata;
          end else begin
            n_rd++;
            rsp_pending = 1;
            rsp_wait = lat;
          end
          wcnt = 0;
        end else wcnt++;
      end
    end
    @(negedge clk);
    if (core_rsp_valid) pulse_bad = 1;
  endtask

  task automatic do_op(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] wd, input int lat);
    int idx, tg, w;
    bit hit;
    logic [DW-1:0] exp_rd, got;
    w   = int'(a[AW-1:2]);
    idx = w % NL;
    tg  = w / NL;
    hit = ref_vld[idx] && (ref_tag[idx] == 4'(tg));
    exp_rd = wr ? wd : mem_model[w];
    if (hit) exp_hits++; else exp_miss++;
    ref_vld[idx] = 1'b1;
    ref_tag[idx] = 4'(tg);
    access(wr, a, wd, lat, got);
    chk(wr ? "R10 write response data" : (hit ? "R4 read hit data" : "R5 read miss data"), got, exp_rd);
    chk("R3 R9 hit_count", 32'(hit_count), 32'(exp_hits));
    chk("R3 R9 miss_count", 32'(miss_count), 32'(exp_miss));
    if (!wr && hit) begin
      chk("R4 no memory request on read hit", 32'(n_req), 0);
      chk("R4 response one cycle after accept", 32'(iters), 1);
    end else if (!wr) begin
      chk("R5 single memory read on miss", {30'd0, n_rd[0], n_wr[0]}, 32'b10);
      chk("R5 request count", 32'(n_req), 1);
    end else begin
      chk(hit ? "R6 single write hit memory write" : "R7 write miss writes only", 32'(n_wr * 16 + n_rd), 16);
      chk("R6 R7 memory write data", {31'd0, wdat_bad}, 0);
    end
    chk("R2 memory request word address", {31'd0, addr_bad}, 0);
    chk("R8 ready low while memory busy", {31'd0, busy_bad}, 0);
    chk("R10 single-cycle response", {31'd0, pulse_bad}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NWORDS; i++) mem_model[i] = 32'h1000_0000 + 32'(i) * 32'h0001_0203;
    for (int i = 0; i < NL; i++) begin ref_vld[i] = 1'b0; ref_tag[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready after reset", {31'd0, core_req_ready}, 1);
    chk("R1 no response after reset", {31'd0, core_rsp_valid}, 0);
    chk("R1 no memory request after reset", {31'd0, mem_req_valid}, 0);
    chk("R1 hit_count zero", 32'(hit_count), 0);
    chk("R1 miss_count zero", 32'(miss_count), 0);

    // Sweep every word with rotating offsets: each access evicts its index (R1, R3, R5)
    for (int w = 0; w < NWORDS; w++) do_op(1'b0, AW'(w * 4 + (w % 4)), '0, w % 3);
    // Resident words read at every byte offset: hits (R2, R4)
    for (int w = NWORDS - NL; w < NWORDS; w++)
      for (int off = 0; off < 4; off++) do_op(1'b0, AW'(w * 4 + off), '0, 1);
    // Write sweep with read-back (R6, R7)
    for (int w = 0; w < NWORDS; w++) begin
      do_op(1'b1, AW'(w * 4), 32'hC0DE_0000 ^ (32'(w) * 32'h0101_0101), (w + 1) % 3);
      do_op(1'b0, AW'(w * 4 + 3), '0, 0);
    end
    // Write hits on resident lines (R6)
    for (int w = NWORDS - NL; w < NWORDS; w++) begin
      do_op(1'b1, AW'(w * 4 + 2), 32'hFACE_0000 + 32'(w), 2);
      do_op(1'b0, AW'(w * 4 + 1), '0, 1);
    end
    // Aliasing pair on one index: valid line with wrong tag misses (R3)
    for (int k = 0; k < 8; k++) do_op(1'b0, (k % 2 == 0) ? 8'h04 : 8'h44, '0, k % 3);
    // Reverse-order read sweep (R5)
    for (int w = NWORDS - 1; w >= 0; w--) do_op(1'b0, AW'(w * 4 + 1), '0, w % 2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule